// File: doc/BRIEF.md
# Configuration Port Word Streamer

This block moves one block of already decrypted and authenticated configuration data from a 128-bit-wide on-chip buffer into a 32-bit internal device configuration port. A single-cycle start pulse supplies the buffer address of the block's first entry, the block length in bits and a flag that marks the final block of a bitstream. The streamer then reads the buffer entries in sequence and splits each entry into four 32-bit port words. While a word is written, both active-low port strobes are driven low.

An upstream controller can hold a pause input high to suspend the transfer at any word. The block then keeps its place and carries on with the same word when the pause is released. After the final block of a bitstream, the streamer adds a short run of flush cycles so that the configuration logic empties its internal pipeline. A busy output covers the whole transfer, including the port's output register stage. While busy is high, further start pulses are ignored.

The buffer is a synchronous memory with a read latency of one clock cycle. The streamer reads the next entry ahead of time, so that a block leaves the port as one unbroken run of words.

Top module: `cfg_word_streamer`

## Requirements
- R1: After reset, `port_wr_n_o` and `port_ce_n_o` are 1, `busy_o` is 0 and `buf_rd_en_o` is 0.
- R2: Block entries are taken from consecutive buffer addresses starting at `base_addr_i`, wrapping modulo 2^ADDR_W. Each entry is sent as bits [127:96] first, then [95:64], then [63:32], then [31:0]. Every sent word has both `port_wr_n_o` and `port_ce_n_o` low.
- R3: With no pause, the first word reaches the port on the third rising edge after the edge that accepts start. A block of N entries is then sent on 4N consecutive cycles.
- R4: When `last_blk_i` was 1 at start, exactly 5 flush cycles follow the final word directly. In each flush cycle `port_ce_n_o` is 0, `port_wr_n_o` is 1 and the data is 0. When the flag was 0, no flush cycle follows.
- R5: The block length is floor(`blk_bits_i` / 128) entries, so the low seven bits of the length are ignored. A start whose length holds no whole entry is ignored: busy stays 0 and no read or write follows.
- R6: During streaming, each rising edge at which `pause_i` is 1 withholds one word, with both strobes held high. The transfer resumes at the word that was withheld, so the block ends later by exactly the number of paused edges.
- R7: `busy_o` rises on the edge that accepts start. It stays 1 until the cycle after the last write or flush cycle seen at the port, and falls on the following edge.
- R8: A start pulse while `busy_o` is 1 is ignored. The running block is unaffected and no further transfer follows.
- R9: `buf_rd_en_o` is never high on two consecutive cycles. Each entry of the block is read exactly once, so one block issues N reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to stream one block |
| blk_bits_i | input | LEN_W | Block length in bits |
| last_blk_i | input | 1 | Block is the final one of the bitstream |
| base_addr_i | input | ADDR_W | Buffer address of the block's first entry |
| pause_i | input | 1 | Suspend word writes while high |
| buf_rd_en_o | output | 1 | Buffer read request |
| buf_rd_addr_o | output | ADDR_W | Buffer read address |
| buf_rd_data_i | input | ENTRY_W | Buffer read data, valid one cycle after the request |
| port_data_o | output | WORD_W | Configuration port data word |
| port_wr_n_o | output | 1 | Active-low write strobe |
| port_ce_n_o | output | 1 | Active-low port enable |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench builds the block with its default parameters: 128-bit entries, 32-bit words, an 8-bit buffer address, a 16-bit length and 5 flush cycles. The 8-bit address lets a three-entry block starting at address 254 wrap round to address 0. The 16-bit length lets lengths with stray low bits and lengths below one entry be driven directly. Pauses are placed both inside an entry and exactly on an entry boundary, where the prefetched entry has to survive the stall.

// File: rtl/cws_pkg.sv
package cws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRIME  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_STREAM = 3'd3,
        ST_FLUSH  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/cws_seq.sv
module cws_seq
    import cws_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int WPE       = 4,
    parameter int ENTRY_LOG = 7,
    parameter int FLUSH_CYC = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 port_idle_i,
    input  logic [LEN_W-1:0]     blk_bits_i,
    input  logic                 last_i,
    input  logic                 pause_i,
    output logic                 accept_o,
    output logic                 prime_o,
    output logic                 load_first_o,
    output logic                 emit_o,
    output logic [$clog2(WPE)-1:0] sub_o,
    output logic                 prefetch_o,
    output logic                 advance_o,
    output logic                 flush_o,
    output logic                 active_o
);

    localparam int SUB_W = $clog2(WPE);
    localparam int FL_W  = $clog2(FLUSH_CYC + 2);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(WPE - 1);
    localparam logic [LEN_W-1:0] WPE_L    = LEN_W'(WPE);
    localparam logic [FL_W-1:0]  FL_INIT  = FL_W'(FLUSH_CYC);

    typedef struct packed {
        seq_state_e       state;
        logic [LEN_W-1:0] words;
        logic [SUB_W-1:0] sub;
        logic [FL_W-1:0]  flush;
        logic             last;
    } seq_t;

    seq_t r_q, r_d;
    logic [LEN_W-1:0] entries;

    assign entries  = blk_bits_i >> ENTRY_LOG;
    assign sub_o    = r_q.sub;
    assign active_o = (r_q.state != ST_IDLE);

    always_comb begin
        r_d          = r_q;
        accept_o     = 1'b0;
        prime_o      = 1'b0;
        load_first_o = 1'b0;
        emit_o       = 1'b0;
        prefetch_o   = 1'b0;
        advance_o    = 1'b0;
        flush_o      = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i && port_idle_i && (entries != '0)) begin
                    accept_o  = 1'b1;
                    r_d.state = ST_PRIME;
                    r_d.words = entries * WPE_L;
                    r_d.sub   = '0;
                    r_d.last  = last_i;
                end
            end
            ST_PRIME: begin
                prime_o   = 1'b1;
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                load_first_o = 1'b1;
                r_d.state    = ST_STREAM;
            end
            ST_STREAM: begin
                if (!pause_i) begin
                    emit_o     = 1'b1;
                    prefetch_o = (r_q.sub == '0) && (r_q.words > WPE_L);
                    advance_o  = (r_q.sub == SUB_LAST);
                    r_d.sub    = (r_q.sub == SUB_LAST) ? '0 : r_q.sub + 1'b1;
                    r_d.words  = r_q.words - 1'b1;
                    if (r_q.words == LEN_W'(1)) begin
                        if (r_q.last && (FLUSH_CYC > 0)) begin
                            r_d.state = ST_FLUSH;
                            r_d.flush = FL_INIT;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
            end
            ST_FLUSH: begin
                flush_o   = 1'b1;
                r_d.flush = r_q.flush - 1'b1;
                if (r_q.flush == FL_W'(1)) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STREAM && pause_i) |=> ($stable(r_q.words) && $stable(r_q.sub))); // R6
    AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (r_q.flush != '0 && r_q.flush <= FL_INIT)); // R4
    AST_LAST_WORD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_o && r_q.words == LEN_W'(1) && r_q.last && FLUSH_CYC > 0) |=> flush_o); // R4
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && start_i) |-> !accept_o); // R8

endmodule

// File: rtl/cws_fetch.sv
module cws_fetch #(
    parameter int ENTRY_W = 128,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic               prime_i,
    input  logic               prefetch_i,
    input  logic               load_first_i,
    input  logic               advance_i,
    input  logic [ENTRY_W-1:0] rd_data_i,
    output logic               rd_en_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic [ENTRY_W-1:0] entry_o
);

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic               pend;
        logic [ENTRY_W-1:0] entry;
        logic [ENTRY_W-1:0] nxt;
    } fetch_t;

    fetch_t r_q, r_d;

    assign rd_en_o   = prime_i | prefetch_i;
    assign rd_addr_o = r_q.addr;
    assign entry_o   = r_q.entry;

    always_comb begin
        r_d      = r_q;
        r_d.pend = rd_en_o;
        if (accept_i) begin
            r_d.addr = base_i;
        end else if (rd_en_o) begin
            r_d.addr = r_q.addr + 1'b1;
        end
        if (load_first_i) begin
            r_d.entry = rd_data_i;
        end else if (r_q.pend) begin
            r_d.nxt = rd_data_i;
        end
        if (advance_i) begin
            r_d.entry = r_q.nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o); // R9
    AST_FIRST_LOAD_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_first_i |-> r_q.pend); // R9

endmodule

// File: rtl/cws_port.sv
module cws_port #(
    parameter int ENTRY_W = 128,
    parameter int WORD_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 emit_i,
    input  logic [$clog2(ENTRY_W/WORD_W)-1:0] sub_i,
    input  logic [ENTRY_W-1:0]   entry_i,
    input  logic                 flush_i,
    output logic [WORD_W-1:0]    data_o,
    output logic                 wr_n_o,
    output logic                 ce_n_o
);

    localparam int WPE = ENTRY_W / WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              wr_n;
        logic              ce_n;
    } port_t;

    port_t r_q, r_d;
    logic [WORD_W-1:0] lanes [WPE];

    for (genvar k = 0; k < WPE; k++) begin : g_lane
        assign lanes[k] = entry_i[ENTRY_W-1-k*WORD_W -: WORD_W];
    end

    always_comb begin
        r_d.data = '0;
        r_d.wr_n = 1'b1;
        r_d.ce_n = 1'b1;
        if (emit_i) begin
            r_d.data = lanes[sub_i];
            r_d.wr_n = 1'b0;
            r_d.ce_n = 1'b0;
        end else if (flush_i) begin
            r_d.ce_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{data: '0, wr_n: 1'b1, ce_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o = r_q.data;
    assign wr_n_o = r_q.wr_n;
    assign ce_n_o = r_q.ce_n;

    AST_EMIT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        emit_i |=> (!wr_n_o && !ce_n_o)); // R2
    AST_FLUSH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (wr_n_o && !ce_n_o && data_o == '0)); // R4

endmodule

// File: rtl/cfg_word_streamer.sv
module cfg_word_streamer #(
    parameter int ENTRY_W   = 128,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 16,
    parameter int FLUSH_CYC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   blk_bits_i,
    input  logic               last_blk_i,
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic               pause_i,
    output logic               buf_rd_en_o,
    output logic [ADDR_W-1:0]  buf_rd_addr_o,
    input  logic [ENTRY_W-1:0] buf_rd_data_i,
    output logic [WORD_W-1:0]  port_data_o,
    output logic               port_wr_n_o,
    output logic               port_ce_n_o,
    output logic               busy_o
);

    localparam int WPE       = ENTRY_W / WORD_W;
    localparam int SUB_W     = $clog2(WPE);
    localparam int ENTRY_LOG = $clog2(ENTRY_W);

    logic             accept, prime, load_first, emit, prefetch, advance, flush, active;
    logic [SUB_W-1:0] sub;
    logic [ENTRY_W-1:0] entry;
    logic             port_idle;

    assign port_idle = port_wr_n_o && port_ce_n_o;
    assign busy_o    = active || !port_idle;

    cws_seq #(
        .LEN_W     (LEN_W),
        .WPE       (WPE),
        .ENTRY_LOG (ENTRY_LOG),
        .FLUSH_CYC (FLUSH_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .port_idle_i  (port_idle),
        .blk_bits_i   (blk_bits_i),
        .last_i       (last_blk_i),
        .pause_i      (pause_i),
        .accept_o     (accept),
        .prime_o      (prime),
        .load_first_o (load_first),
        .emit_o       (emit),
        .sub_o        (sub),
        .prefetch_o   (prefetch),
        .advance_o    (advance),
        .flush_o      (flush),
        .active_o     (active)
    );

    cws_fetch #(
        .ENTRY_W (ENTRY_W),
        .ADDR_W  (ADDR_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .base_i       (base_addr_i),
        .prime_i      (prime),
        .prefetch_i   (prefetch),
        .load_first_i (load_first),
        .advance_i    (advance),
        .rd_data_i    (buf_rd_data_i),
        .rd_en_o      (buf_rd_en_o),
        .rd_addr_o    (buf_rd_addr_o),
        .entry_o      (entry)
    );

    cws_port #(
        .ENTRY_W (ENTRY_W),
        .WORD_W  (WORD_W)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .emit_i  (emit),
        .sub_i   (sub),
        .entry_i (entry),
        .flush_i (flush),
        .data_o  (port_data_o),
        .wr_n_o  (port_wr_n_o),
        .ce_n_o  (port_ce_n_o)
    );

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && ((blk_bits_i >> ENTRY_LOG) != '0)) |=> busy_o); // R7
    AST_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !buf_rd_en_o); // R5

endmodule

// File: tb/cfg_word_streamer_bench.sv
`timescale 1ns/1ps
module cfg_word_streamer_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [15:0]  blk_bits_i = '0;
    logic         last_blk_i = 1'b0;
    logic [7:0]   base_addr_i = '0;
    logic         pause_i = 1'b0;
    logic         buf_rd_en_o;
    logic [7:0]   buf_rd_addr_o;
    logic [127:0] buf_rd_data_i = '0;
    logic [31:0]  port_data_o;
    logic         port_wr_n_o, port_ce_n_o, busy_o;

    int checks = 0;
    int errors = 0;
    logic [127:0] mem [256];

    always #2.5 clk = ~clk;

    cfg_word_streamer u_cfg_word_streamer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_bits_i(blk_bits_i),
        .last_blk_i(last_blk_i), .base_addr_i(base_addr_i), .pause_i(pause_i),
        .buf_rd_en_o(buf_rd_en_o), .buf_rd_addr_o(buf_rd_addr_o),
        .buf_rd_data_i(buf_rd_data_i), .port_data_o(port_data_o),
        .port_wr_n_o(port_wr_n_o), .port_ce_n_o(port_ce_n_o), .busy_o(busy_o)
    );

    always_ff @(posedge clk) begin
        if (buf_rd_en_o) buf_rd_data_i <= mem[buf_rd_addr_o];
    end

    function automatic logic [31:0] pat(int a, int k);
        return {8'hC5, 8'(a), 8'(k), 8'(a * 3 + k + 17)};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(port_wr_n_o == 1'b1, "R1", "wr_n in reset", port_wr_n_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(port_wr_n_o == 1'b1 && port_ce_n_o == 1'b1, "R1", "strobes after reset",
            {port_wr_n_o, port_ce_n_o}, 3);
        chk(busy_o == 1'b0 && buf_rd_en_o == 1'b0, "R1", "busy/read after reset",
            {busy_o, buf_rd_en_o}, 0);
    endtask

    // One block; returns after busy has been low for several cycles.
    task automatic run_block(string req, int base, int bits, bit last,
                             int pause_after, int pause_len, bit poke);
        int nent = bits / 128;
        int w    = nent * 4;
        int fl   = last ? 5 : 0;
        int nw = 0, firstc = -1, lastc = -1, flc = 0, rds = 0, bad = 0;
        int dropc = -1, extra = 0, pcnt = 0, c = 0;
        bit busy1 = 1'b0;
        @(negedge clk);
        blk_bits_i = 16'(bits); base_addr_i = 8'(base); last_blk_i = last; start_i = 1'b1;
        while (c < 3000) begin
            @(negedge clk);
            c++;
            if (c == 1) begin start_i = 1'b0; busy1 = busy_o; end
            if (buf_rd_en_o) rds++;
            if (!port_wr_n_o && !port_ce_n_o) begin
                if (dropc >= 0) extra++;
                else begin
                    if (port_data_o != pat((base + nw / 4) % 256, nw % 4)) begin
                        if (bad == 0)
                            chk(0, "R2", "word data", port_data_o,
                                pat((base + nw / 4) % 256, nw % 4));
                        bad++;
                    end
                    if (nw == 0) firstc = c;
                    lastc = c;
                    nw++;
                end
            end
            if (port_wr_n_o && !port_ce_n_o) flc++;
            if (dropc >= 0 && busy_o) extra++;
            if (!busy_o && c > 1 && dropc < 0) dropc = c;
            if (pause_len > 0 && nw >= pause_after && pcnt < pause_len) begin
                pause_i = 1'b1; pcnt++;
            end else pause_i = 1'b0;
            if (poke && c == 6) begin
                start_i = 1'b1; base_addr_i = 8'(base + 100); blk_bits_i = 16'd512; last_blk_i = 1'b1;
            end
            if (poke && c == 7) start_i = 1'b0;
            if (dropc >= 0 && c >= dropc + 8) break;
        end
        if (c >= 3000) chk(0, req, "block never finished", c, 0);
        chk(busy1 == 1'b1, "R7", "busy after start", busy1, 1);
        chk(firstc == 4, "R3", "first word cycle", firstc, 4);
        chk(nw == w, "R5", "word count", nw, w);
        if (bad == 0) chk(1, "R2", "word data and order", 0, 0);
        chk(lastc == 3 + w + pause_len, (pause_len > 0) ? "R6" : "R3", "last word cycle",
            lastc, 3 + w + pause_len);
        chk(flc == fl, "R4", "flush cycles", flc, fl);
        chk(dropc == 4 + w + fl + pause_len, "R7", "busy drop cycle", dropc, 4 + w + fl + pause_len);
        chk(rds == nent, "R9", "buffer reads", rds, nent);
        if (poke) chk(extra == 0, "R8", "activity after ignored start", extra, 0);
        else chk(extra == 0, req, "activity after block", extra, 0);
    endtask

    task automatic t_zero_len;
        int act = 0;
        @(negedge clk);
        blk_bits_i = 16'd100; base_addr_i = 8'd5; last_blk_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (busy_o || buf_rd_en_o || !port_wr_n_o || !port_ce_n_o) act++;
            @(negedge clk);
        end
        chk(act == 0, "R5", "start with no whole entry", act, 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++)
            mem[a] = {pat(a, 0), pat(a, 1), pat(a, 2), pat(a, 3)};
        t_reset();
        run_block("R2", 10, 128, 1'b0, 0, 0, 1'b0);
        run_block("R4", 40, 384, 1'b1, 0, 0, 1'b0);
        run_block("R5", 254, 3 * 128 + 77, 1'b0, 0, 0, 1'b0);
        run_block("R6", 90, 512, 1'b1, 5, 3, 1'b0);
        run_block("R6", 120, 256, 1'b0, 4, 2, 1'b0);
        run_block("R8", 60, 256, 1'b0, 0, 0, 1'b1);
        t_zero_len();
        run_block("R3", 0, 128 * 6, 1'b1, 0, 0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule